// File: doc/BRIEF.md
# Strobe-Addressed Synthesizer Register File

This block is the receiving end of a narrow configuration port for a clock synthesizer. A host drives a 4-bit bus and one active-low strobe. The two edges of the strobe separate the two phases of a write. On the falling edge the bus is taken as a register address. On the rising edge that follows, the bus is taken as the data nibble for that register. The strobe and the bus are oversampled in the system clock domain, and edges are found there.

The sixteen 4-bit registers are mapped onto the divider and loop-control fields that the synthesizer core uses. Only the bits that feed a field get storage. These fields are the reference-divider code, the feedback A and M codes, VCO gain, phase-detector gain, post-scaler select and phase-detector reset enable. A programming session is not taken up at once. The effective fields stay at zero until 32 writes have been received since reset. From that point each completed write reaches the effective outputs a few cycles later.

Top module: `synth_regfile_rx`

## Requirements
- R1: After a synchronous active-low reset, every effective output field reads zero.
- R2: The bus value sampled at a falling strobe edge is the register address. The bus value sampled at the next rising edge is written as data into that register.
- R3: A rising strobe edge with no falling edge since reset or since the last write is ignored. It writes nothing and does not count toward the write threshold.
- R4: Until 32 writes have been counted, all effective outputs hold zero, whatever the registers contain.
- R5: The 32nd write arms the block. After that, every write reaches the effective outputs within 6 clock cycles of the strobe's rising edge.
- R6: The 7-bit reference code is register 0 bits 3:0 (low part) joined with register 1 bits 2:0 (high part). Register 1 bit 3 has no effect.
- R7: The 6-bit M code is register 3 bits 3:0 (low part) joined with register 4 bits 1:0 (high part). Register 4 bits 3:2 have no effect.
- R8: The A code is register 2. VCO gain is register 8 bits 2:0. Phase-detector gain is register 9 bits 1:0. Post-scale select is register 11 bits 1:0. Reset enable is register 15 bit 3.
- R9: Writes to registers that feed no field (such as 5, 12, 13 and 14) count toward the threshold and leave every output unchanged.
- R10: Once armed, the block stays armed until reset, however many more writes arrive.
- R11: A reset during operation disarms the block and clears the fields. Writes after it stay hidden until 32 more have been counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_strobe_n | input | 1 | Asynchronous write strobe, active low |
| cfg_bus | input | 4 | Address during the strobe's falling edge, data at its rising edge |
| ref_div_code | output | 7 | Effective reference-divider code |
| fb_a_code | output | 4 | Effective feedback A code |
| fb_m_code | output | 6 | Effective feedback M code |
| vco_gain_sel | output | 3 | Effective VCO gain select |
| pd_gain_sel | output | 2 | Effective phase-detector gain |
| post_scale_sel | output | 2 | Effective post-scaler select |
| pd_reset_en | output | 1 | Effective phase-detector reset enable |

## Verification
The bench builds the block with its defaults: sixteen registers, 4-bit nibbles, a two-stage synchronizer and a 32-write threshold. Each write takes about 20 cycles, so the full threshold is inside the run. The bench checks outputs after each of the 31 writes before arming and then after the 32nd, so the exact boundary is visible. An orphan rising edge is placed before the sequence, so a miscounted edge would arm the block one write early. The same threshold also lets a reset in mid-operation be followed by a write that must stay hidden.

// File: rtl/synth_cfg_pkg.sv
// Package: shared field record and the map from each field bit to the
// register and bit that holds it. Assumes 4-bit registers.
package synth_cfg_pkg;

    localparam int FIELD_W = 25;

    typedef struct packed {
        logic [6:0] ref_div;
        logic [3:0] fb_a;
        logic [5:0] fb_m;
        logic [2:0] vco_gain;
        logic [1:0] pd_gain;
        logic [1:0] post_sel;
        logic       pd_rst_en;
    } synth_fields_t;

    // Register index that feeds packed field bit k (bit 0 = pd_rst_en).
    function automatic int src_reg(input int k);
        if (k == 0)  return 15;
        if (k <= 2)  return 11;
        if (k <= 4)  return 9;
        if (k <= 7)  return 8;
        if (k <= 11) return 3;
        if (k <= 13) return 4;
        if (k <= 17) return 2;
        if (k <= 21) return 0;
        return 1;
    endfunction

    // Bit position inside that register for packed field bit k.
    function automatic int src_bit(input int k);
        if (k == 0)  return 3;
        if (k <= 2)  return k - 1;
        if (k <= 4)  return k - 3;
        if (k <= 7)  return k - 5;
        if (k <= 11) return k - 8;
        if (k <= 13) return k - 12;
        if (k <= 17) return k - 14;
        if (k <= 21) return k - 18;
        return k - 22;
    endfunction

    // True when at least one field bit lives in register r.
    function automatic logic reg_mapped(input int r);
        for (int k = 0; k < FIELD_W; k++) begin
            if (src_reg(k) == r) return 1'b1;
        end
        return 1'b0;
    endfunction

endpackage

// File: rtl/strobe_edge_sync.sv
// Module: strobe_edge_sync
// Oversamples the asynchronous strobe and bus through STAGES flops and
// flags the strobe's falling and rising edges in the clock domain.
// Assumes the host holds the bus steady for more than STAGES cycles
// around each strobe edge. The synchronizer flops have no reset, so the
// strobe level seen at reset release does not count as an edge.
module strobe_edge_sync #(
    parameter int STAGES = 2,
    parameter int BUS_W  = 4
) (
    input  logic             clk,
    input  logic             strb_n_in,
    input  logic [BUS_W-1:0] bus_in,
    output logic             fall_o,
    output logic             rise_o,
    output logic [BUS_W-1:0] bus_o
);
    logic [STAGES:0]  strb_pipe;
    logic [BUS_W-1:0] bus_pipe [STAGES];

    // Shift the strobe, with one extra stage kept as history.
    always_ff @(posedge clk) begin
        strb_pipe <= {strb_pipe[STAGES-1:0], strb_n_in};
    end

    // Delay the bus by the same depth so it lines up with the strobe.
    always_ff @(posedge clk) begin
        bus_pipe[0] <= bus_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_bus_stage
        // Next bus stage.
        always_ff @(posedge clk) begin
            bus_pipe[s] <= bus_pipe[s-1];
        end
    end

    assign fall_o = strb_pipe[STAGES] & ~strb_pipe[STAGES-1];
    assign rise_o = ~strb_pipe[STAGES] & strb_pipe[STAGES-1];
    assign bus_o  = bus_pipe[STAGES-1];
endmodule

// File: rtl/strobe_bus_capture.sv
// Module: strobe_bus_capture
// Holds the address taken at a falling edge. On the next rising edge it
// issues a one-cycle write carrying that address and the bus nibble.
// A rising edge with no address held is dropped.
module strobe_bus_capture #(
    parameter int BUS_W  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic [BUS_W-1:0]  bus_i,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BUS_W-1:0]  wr_data
);
    logic [ADDR_W-1:0] addr_q;
    logic              addr_valid;

    // Address phase on a fall, data phase on a matched rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            addr_valid <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (fall_i) begin
                addr_q     <= bus_i[ADDR_W-1:0];
                addr_valid <= 1'b1;
            end else if (rise_i && addr_valid) begin
                wr_en      <= 1'b1;
                wr_addr    <= addr_q;
                wr_data    <= bus_i;
                addr_valid <= 1'b0;
            end
        end
    end

    // R3: a write only ever follows a held address.
    p_wr_needs_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(addr_valid));

    // R2: one strobe cycle gives exactly one write pulse.
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/field_store.sv
// Module: field_store
// Keeps only the register bits that feed a synthesizer field, one flop
// per field bit. Writes to bits or registers with no field leave no
// trace. Assumes 4-bit data and the fixed field map in the package.
module field_store
    import synth_cfg_pkg::*;
#(
    parameter int BUS_W  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output synth_fields_t     fields_o
);
    logic [FIELD_W-1:0] fields_q;

    for (genvar k = 0; k < FIELD_W; k++) begin : g_field_bit
        localparam int SR = src_reg(k);
        localparam int SB = src_bit(k);
        // Load this bit when its own register is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fields_q[k] <= 1'b0;
            end else if (wr_en && (wr_addr == ADDR_W'(SR))) begin
                fields_q[k] <= wr_data[SB];
            end
        end
    end

    assign fields_o = synth_fields_t'(fields_q);

    // R2: a write to the A register lands in the A field.
    p_a_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(2)) |=> fields_o.fb_a == $past(wr_data));

    // R9: a write to a register with no field changes nothing.
    p_unmapped_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_mapped(int'(wr_addr))) |=> $stable(fields_q));
endmodule

// File: rtl/arm_gate.sv
// Module: arm_gate
// Counts writes after reset. It saturates at ARM_WRITES and from then
// copies the stored fields onto the effective outputs every cycle.
// Before that the effective outputs are held at zero.
module arm_gate
    import synth_cfg_pkg::*;
#(
    parameter int ARM_WRITES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  synth_fields_t fields_i,
    output synth_fields_t eff_o
);
    localparam int              CNT_W   = $clog2(ARM_WRITES + 1);
    localparam logic [CNT_W-1:0] ARM_CNT = CNT_W'(ARM_WRITES);

    logic [CNT_W-1:0] cnt_q;
    logic             armed;

    assign armed = (cnt_q == ARM_CNT);

    // Saturating write counter and the gated effective copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            eff_o <= '0;
        end else begin
            if (wr_en && !armed) cnt_q <= cnt_q + 1'b1;
            if (armed)           eff_o <= fields_i;
        end
    end

    // R4: outputs stay cleared while the block is not armed.
    p_hold_disarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> eff_o == '0);

    // R3: the count moves only because of a write pulse.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> $past(wr_en));

    // R10: once armed, armed until reset.
    p_arm_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R10: the counter never runs past the threshold.
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= ARM_CNT);
endmodule

// File: rtl/synth_regfile_rx.sv
// Module: synth_regfile_rx (top)
// Receives strobe-addressed nibble writes into the synthesizer register
// set. It shows the field values only after the arming write count.
// Assumes a 4-bit bus that carries both address and data.
module synth_regfile_rx
    import synth_cfg_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int NIB_W       = 4,
    parameter int ARM_WRITES  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_strobe_n,
    input  logic [NIB_W-1:0] cfg_bus,
    output logic [6:0]       ref_div_code,
    output logic [3:0]       fb_a_code,
    output logic [5:0]       fb_m_code,
    output logic [2:0]       vco_gain_sel,
    output logic [1:0]       pd_gain_sel,
    output logic [1:0]       post_scale_sel,
    output logic             pd_reset_en
);
    localparam int ADDR_W = $clog2(NUM_REGS);

    logic              fall, rise;
    logic [NIB_W-1:0]  bus_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [NIB_W-1:0]  wr_data;
    synth_fields_t     stored, eff;

    strobe_edge_sync #(.STAGES(SYNC_STAGES), .BUS_W(NIB_W)) u_sync (
        .clk(clk), .strb_n_in(cfg_strobe_n), .bus_in(cfg_bus),
        .fall_o(fall), .rise_o(rise), .bus_o(bus_s));

    strobe_bus_capture #(.BUS_W(NIB_W), .ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .fall_i(fall), .rise_i(rise), .bus_i(bus_s),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    field_store #(.BUS_W(NIB_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fields_o(stored));

    arm_gate #(.ARM_WRITES(ARM_WRITES)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fields_i(stored),
        .eff_o(eff));

    assign ref_div_code   = eff.ref_div;
    assign fb_a_code      = eff.fb_a;
    assign fb_m_code      = eff.fb_m;
    assign vco_gain_sel   = eff.vco_gain;
    assign pd_gain_sel    = eff.pd_gain;
    assign post_scale_sel = eff.post_sel;
    assign pd_reset_en    = eff.pd_rst_en;
endmodule

// File: tb/synth_regfile_rx_tb.sv
module synth_regfile_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strb_n = 1'b0;
    logic [3:0] bus = 4'h0;
    logic [6:0] ref_div_code;
    logic [3:0] fb_a_code;
    logic [5:0] fb_m_code;
    logic [2:0] vco_gain_sel;
    logic [1:0] pd_gain_sel;
    logic [1:0] post_scale_sel;
    logic       pd_reset_en;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    synth_regfile_rx u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_strobe_n(strb_n), .cfg_bus(bus),
        .ref_div_code(ref_div_code), .fb_a_code(fb_a_code),
        .fb_m_code(fb_m_code), .vco_gain_sel(vco_gain_sel),
        .pd_gain_sel(pd_gain_sel), .post_scale_sel(post_scale_sel),
        .pd_reset_en(pd_reset_en));

    // Packed expectation: {ref7, a4, m6, vco3, pd2, post2, en1}.
    localparam logic [24:0] Z     = 25'd0;
    localparam logic [24:0] E_ARM = {7'd53, 4'd2, 6'd34, 3'd4, 2'd1, 2'd2, 1'b1};

    // {addr, data, expected effective word after the write}.
    // Entries 0-30 must leave outputs at zero (R4), dummy ones are R9.
    localparam logic [32:0] VEC [0:31] = '{
        {4'd13, 4'h3, Z}, {4'd14, 4'h7, Z}, {4'd13, 4'hF, Z}, {4'd14, 4'h1, Z},
        {4'd13, 4'h0, Z}, {4'd14, 4'h9, Z}, {4'd13, 4'hA, Z}, {4'd14, 4'h5, Z},
        {4'd13, 4'h6, Z}, {4'd14, 4'hC, Z}, {4'd13, 4'h2, Z}, {4'd14, 4'hE, Z},
        {4'd13, 4'h4, Z}, {4'd14, 4'h8, Z}, {4'd13, 4'hB, Z}, {4'd14, 4'hD, Z},
        {4'd13, 4'h1, Z}, {4'd14, 4'h3, Z}, {4'd13, 4'h5, Z}, {4'd14, 4'h7, Z},
        {4'd13, 4'h9, Z},
        {4'd0,  4'h5, Z}, {4'd1,  4'hB, Z}, {4'd2,  4'h2, Z}, {4'd3,  4'h2, Z},
        {4'd4,  4'hE, Z}, {4'd8,  4'hC, Z}, {4'd9,  4'h5, Z}, {4'd11, 4'h6, Z},
        {4'd5,  4'hF, Z}, {4'd12, 4'hF, Z},
        {4'd15, 4'h8, E_ARM}
    };

    function automatic logic [24:0] outs();
        return {ref_div_code, fb_a_code, fb_m_code, vco_gain_sel,
                pd_gain_sel, post_scale_sel, pd_reset_en};
    endfunction

    task automatic check(input string tag, input logic [24:0] exp);
        n_checks++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, outs(), exp);
        end
    endtask

    // One full strobe cycle: address phase, then data phase.
    task automatic do_write(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk); bus = a;
        repeat (3) @(negedge clk); strb_n = 1'b0;
        repeat (4) @(negedge clk); bus = d;
        repeat (3) @(negedge clk); strb_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [24:0] e;
        // Strobe held low through reset so its release is not a fall.
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset state", Z);

        // R3: orphan rising edge; if counted, arming would come one write early.
        bus = 4'd2;
        @(negedge clk); strb_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R3 orphan rise", Z);

        // Table: 31 hidden writes then the arming one (R4, R5, R9).
        for (int i = 0; i < 32; i++) begin
            do_write(VEC[i][32:29], VEC[i][28:25]);
            check(i == 31 ? "R5 arming write" : "R4 before threshold", VEC[i][24:0]);
        end

        // R2 R5 R6: reg0 low bits of reference code, visible at once.
        e = {7'd63, 4'd2, 6'd34, 3'd4, 2'd1, 2'd2, 1'b1};
        do_write(4'd0, 4'hF);  check("R2 R5 R6 ref low", e);
        e[24:18] = 7'd127;
        do_write(4'd1, 4'h7);  check("R6 ref max", e);
        e[13:8] = 6'd47;
        do_write(4'd3, 4'hF);  check("R7 m low", e);
        e[13:8] = 6'd63;
        do_write(4'd4, 4'h3);  check("R7 m high", e);
        do_write(4'd13, 4'hA); check("R9 unmapped write", e);
        do_write(4'd4, 4'hF);  check("R7 m upper bits ignored", e);
        e[17:14] = 4'd0;
        do_write(4'd2, 4'h0);  check("R8 a zero", e);
        e[7:5] = 3'd7;
        do_write(4'd8, 4'h7);  check("R8 vco", e);
        e[4:3] = 2'd2;
        do_write(4'd9, 4'h2);  check("R8 pd gain", e);
        e[2:1] = 2'd3;
        do_write(4'd11, 4'h3); check("R8 post scale", e);
        e[0] = 1'b0;
        do_write(4'd15, 4'h7); check("R8 R10 reset enable bit3", e);

        // R11: reset disarms; a new write stays hidden.
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset clears", Z);
        do_write(4'd2, 4'h9);
        check("R11 disarmed after reset", Z);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule